// File: doc/BRIEF.md
# Synchronous Burst SRAM Control Front End

This block models, cycle by cycle, the control and address path of a pipelined synchronous burst SRAM. On every rising clock edge it samples the address, the chip selects, two burst-start strobes, an advance input, a burst-order mode pin and the write controls. One strobe serves the processor side and the other the cache-controller side. A start loads the external address. After that, the two low address bits step through a four-beat burst while the upper bits stay fixed. The write controls are decoded into per-byte-lane write strobes. A small per-lane storage array lets reads and writes be observed end to end.

A burst begins when either strobe is asserted. Each following cycle with the advance input asserted moves to the next burst position, in linear order (offset plus count, modulo 4) or in interleaved order (offset XOR count). With the advance input deasserted, the current position is accessed again. The sleep input freezes the block: no access, no state change. The primary chip select gates the processor strobe. A start with any chip select inactive ends the burst and performs no access.

Top module: `sburst_sram_ctl`

## Requirements
- R1: While reset is asserted, rd_valid is 0, wr_lanes is 0 and burst_addr is 0.
- R2: A processor-strobe start (pstb_n=0 with ce1_n=0, ce2=1, ce3_n=0) accepts addr at the clock edge. After that edge, burst_addr equals addr, rd_valid is 1 and rdata holds the stored word. The write controls are ignored in this start cycle.
- R3: A controller-strobe start (cstb_n=0, all selects active) accepts addr at the edge and performs a write if the write controls request one, otherwise a read.
- R4: While ce1_n=1, pstb_n is ignored. An active burst continues its sequence and does not load the new address.
- R5: With both strobes asserted and ce1_n=0, the processor strobe wins, so the cycle is a read even when gwr_n=0. With ce1_n=1, the controller strobe starts the burst, which is unselected and therefore performs no access.
- R6: With linear=1, beat k of a burst that starts at offset o accesses low bits (o+k) mod 4.
- R7: With linear=0, beat k accesses low bits o XOR k.
- R8: A burst cycle with adv_n=1 accesses the same address as the previous beat.
- R9: burst_addr[ADDR_W-1:2] stays equal to the start address's upper bits for the whole burst.
- R10: gwr_n=0 writes all lanes whatever bwq_n and lane_we_n are. After the edge, wr_lanes is all ones and rd_valid is 0.
- R11: With gwr_n=1, lane l (bits l*8 .. l*8+7) is written only when bwq_n=0 and lane_we_n[l]=0. After the edge, wr_lanes shows those lanes. If no lane is written, the cycle is a read.
- R12: While sleep=1, no access happens: rd_valid=0, wr_lanes=0, storage and burst position are unchanged. The burst resumes after sleep drops.
- R13: A start with ce2=0 or ce3_n=1 performs no access, and later advance cycles perform none until the next selected start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| sleep | input | 1 | Power-down, active high; all accesses suppressed |
| ce1_n | input | 1 | Primary chip select, active low; gates pstb_n |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| pstb_n | input | 1 | Processor-side burst start, active low |
| cstb_n | input | 1 | Controller-side burst start, active low |
| adv_n | input | 1 | Burst advance, active low |
| linear | input | 1 | Burst order: 1 linear, 0 interleaved (static) |
| gwr_n | input | 1 | Global write, active low |
| bwq_n | input | 1 | Byte-write qualifier, active low |
| lane_we_n | input | NLANES | Per-lane write enables, active low |
| addr | input | ADDR_W | External word address |
| wdata | input | NLANES*LANE_W | Write data |
| rdata | output | NLANES*LANE_W | Registered read data |
| rd_valid | output | 1 | A read took place at the last edge |
| wr_lanes | output | NLANES | Lanes written at the last edge |
| burst_addr | output | ADDR_W | Address accessed at the last access edge |

## Verification
A corrupted burst counter or offset shows at burst_addr on the very next access edge, as a low-bit pair that breaks the linear or XOR sequence. A wrong stored upper base shows on the same edge as changed high bits. A wrong write decode leaves a wrong lane pattern on wr_lanes one edge later, and a wrong byte merge surfaces at rdata on the following read of that word. A missed priority or gating rule turns a read into a write or an access into none, so it is visible one edge later on rd_valid and wr_lanes.

// File: rtl/sburst_pkg.sv
package sburst_pkg;

   // Position of beat cnt within a four-beat burst starting at offset off.
   function automatic logic [1:0] burst_pos(input logic [1:0] off,
                                            input logic [1:0] cnt,
                                            input logic       lin);
      burst_pos = lin ? (off + cnt) : (off ^ cnt);
   endfunction

endpackage

// File: rtl/sburst_seq.sv
module sburst_seq #(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic              start,
   input  logic              sel,
   input  logic              adv,
   input  logic              linear,
   input  logic [ADDR_W-1:0] ext_addr,
   output logic              acc,
   output logic [ADDR_W-1:0] acc_addr
);
   import sburst_pkg::*;

   localparam int HI_W = ADDR_W - 2;

   logic            active_q;
   logic [HI_W-1:0] base_q;
   logic [1:0]      off_q;
   logic [1:0]      cnt_q;
   logic [1:0]      cnt_nx;

   always_comb begin
      cnt_nx = cnt_q + {1'b0, adv};
      if (hold) begin
         acc      = 1'b0;
         acc_addr = {base_q, burst_pos(off_q, cnt_q, linear)};
      end else if (start) begin
         acc      = sel;
         acc_addr = ext_addr;
      end else begin
         acc      = active_q;
         acc_addr = {base_q, burst_pos(off_q, cnt_nx, linear)};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         base_q   <= '0;
         off_q    <= '0;
         cnt_q    <= '0;
      end else if (!hold) begin
         if (start) begin
            active_q <= sel;
            base_q   <= ext_addr[ADDR_W-1:2];
            off_q    <= ext_addr[1:0];
            cnt_q    <= '0;
         end else if (active_q) begin
            cnt_q <= cnt_nx;
         end
      end
   end

   // R8
   hold_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !hold && !start && !adv) |=> $stable(cnt_q));

   // R9
   base_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start || hold) |=> $stable(base_q));

   // R12
   sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> ($stable(cnt_q) && $stable(off_q) && $stable(active_q)));

endmodule

// File: rtl/sburst_lane_dec.sv
module sburst_lane_dec #(
   parameter int NLANES = 4
) (
   input  logic              gwr_n,
   input  logic              bwq_n,
   input  logic              wr_ok,
   input  logic [NLANES-1:0] lane_we_n,
   output logic [NLANES-1:0] lane_wr
);
   for (genvar l = 0; l < NLANES; l++) begin : g_lane
      assign lane_wr[l] = wr_ok & (~gwr_n | (~bwq_n & ~lane_we_n[l]));
   end
endmodule

// File: rtl/sburst_bank.sv
module sburst_bank #(
   parameter int ADDR_W = 8,
   parameter int LANE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              re,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANE_W-1:0] wd,
   output logic [LANE_W-1:0] rd
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rd <= '0;
      else if (re) rd <= mem[addr];
   end
endmodule

// File: rtl/sburst_sram_ctl.sv
module sburst_sram_ctl #(
   parameter int ADDR_W = 8,
   parameter int NLANES = 4,
   parameter int LANE_W = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     sleep,
   input  logic                     ce1_n,
   input  logic                     ce2,
   input  logic                     ce3_n,
   input  logic                     pstb_n,
   input  logic                     cstb_n,
   input  logic                     adv_n,
   input  logic                     linear,
   input  logic                     gwr_n,
   input  logic                     bwq_n,
   input  logic [NLANES-1:0]        lane_we_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [NLANES*LANE_W-1:0] wdata,
   output logic [NLANES*LANE_W-1:0] rdata,
   output logic                     rd_valid,
   output logic [NLANES-1:0]        wr_lanes,
   output logic [ADDR_W-1:0]        burst_addr
);
   localparam int DW = NLANES * LANE_W;

   if (ADDR_W < 3) begin : g_bad_aw
      $error("ADDR_W must be at least 3");
   end
   if (ADDR_W > 12) begin : g_big_aw
      $error("ADDR_W above 12 makes the model array too large");
   end
   if (NLANES < 1) begin : g_bad_nl
      $error("NLANES must be at least 1");
   end
   if (LANE_W < 1) begin : g_bad_lw
      $error("LANE_W must be at least 1");
   end

   logic              pstart, cstart, start, sel;
   logic              acc, do_rd;
   logic [ADDR_W-1:0] acc_addr;
   logic [NLANES-1:0] lane_wr;

   assign sel    = ~ce1_n & ce2 & ~ce3_n;
   assign pstart = ~pstb_n & ~ce1_n;
   assign cstart = ~cstb_n & ~pstart;
   assign start  = pstart | cstart;

   sburst_seq #(.ADDR_W(ADDR_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold     (sleep),
      .start    (start),
      .sel      (sel),
      .adv      (~adv_n),
      .linear   (linear),
      .ext_addr (addr),
      .acc      (acc),
      .acc_addr (acc_addr)
   );

   sburst_lane_dec #(.NLANES(NLANES)) u_dec (
      .gwr_n     (gwr_n),
      .bwq_n     (bwq_n),
      .wr_ok     (~pstart),
      .lane_we_n (lane_we_n),
      .lane_wr   (lane_wr)
   );

   assign do_rd = acc & ~(|lane_wr);

   for (genvar l = 0; l < NLANES; l++) begin : g_bank
      sburst_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (acc & lane_wr[l]),
         .re    (do_rd),
         .addr  (acc_addr),
         .wd    (wdata[l*LANE_W +: LANE_W]),
         .rd    (rdata[l*LANE_W +: LANE_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid   <= 1'b0;
         wr_lanes   <= '0;
         burst_addr <= '0;
      end else begin
         rd_valid <= do_rd;
         wr_lanes <= acc ? lane_wr : '0;
         if (acc) burst_addr <= acc_addr;
      end
   end

   // R12
   sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> (!rd_valid && wr_lanes == '0));

   // R10
   gw_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !gwr_n && !pstart) |=> (wr_lanes == '1));

   // R2
   pstb_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pstart && sel && !sleep) |=> (rd_valid && wr_lanes == '0));

   // R11
   rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> (wr_lanes == '0));

   // R13
   unsel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !sel) |=> (!rd_valid && wr_lanes == '0));

   logic [DW-1:0] unused_dw;
   assign unused_dw = rdata;

endmodule

// File: tb/sim_sburst_sram_ctl.sv
module sim_sburst_sram_ctl;
   localparam int AW = 8;
   localparam int NL = 4;
   localparam int LW = 8;
   localparam int DW = NL * LW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sleep, ce1_n, ce2, ce3_n, pstb_n, cstb_n, adv_n, linear;
   logic          gwr_n, bwq_n;
   logic [NL-1:0] lane_we_n;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata;
   logic [DW-1:0] rdata;
   logic          rd_valid;
   logic [NL-1:0] wr_lanes;
   logic [AW-1:0] burst_addr;

   logic [DW-1:0] model [1 << AW];
   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   sburst_sram_ctl #(.ADDR_W(AW), .NLANES(NL), .LANE_W(LW)) u0 (
      .clk(clk), .rst_n(rst_n), .sleep(sleep), .ce1_n(ce1_n), .ce2(ce2),
      .ce3_n(ce3_n), .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n),
      .linear(linear), .gwr_n(gwr_n), .bwq_n(bwq_n), .lane_we_n(lane_we_n),
      .addr(addr), .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
      .wr_lanes(wr_lanes), .burst_addr(burst_addr)
   );

   task automatic chk(input bit ok, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      sleep = 0; ce1_n = 0; ce2 = 1; ce3_n = 0; pstb_n = 1; cstb_n = 1;
      adv_n = 1; gwr_n = 1; bwq_n = 1; lane_we_n = '1;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [1:0] pos(input logic [1:0] off, input int k, input bit lin);
      logic [1:0] kk;
      kk = k[1:0];
      return lin ? 2'(off + kk) : (off ^ kk);
   endfunction

   function automatic logic [DW-1:0] pat(input logic [7:0] a, input logic [7:0] s);
      return {a ^ s, ~a, 8'(a + s), a};
   endfunction

   function automatic logic [DW-1:0] lane_mask(input logic [NL-1:0] m);
      logic [DW-1:0] r;
      r = '0;
      for (int l = 0; l < NL; l++) if (m[l]) r[l*LW +: LW] = '1;
      return r;
   endfunction

   task automatic check_read(input logic [AW-1:0] a, input string req);
      chk(burst_addr == a, req, 64'(burst_addr), 64'(a));
      chk(rd_valid && wr_lanes == '0 && rdata == model[a], req, 64'(rdata), 64'(model[a]));
   endtask

   // Controller-strobe start at a; full write of d when wr, otherwise read.
   task automatic cstart(input logic [AW-1:0] a, input bit wr, input logic [DW-1:0] d);
      idle(); cstb_n = 0; addr = a;
      if (wr) begin gwr_n = 0; wdata = d; end
      tick();
      if (wr) model[a] = d;
      idle();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] a0, ea, ref_a;
      logic [5:0]    hi;
      logic [DW-1:0] nd;
      idle(); linear = 1; addr = '0; wdata = '0;
      repeat (3) tick();
      // R1
      chk(rd_valid == 0 && wr_lanes == '0 && burst_addr == '0, "R1",
          {rd_valid, wr_lanes, burst_addr}, 0);
      rst_n = 1;
      tick();
      chk(rd_valid == 0 && wr_lanes == '0, "R1", {rd_valid, wr_lanes}, 0);

      // R2 R3 R6 R7 R9: sweep order, start source, offset
      for (int lin = 0; lin < 2; lin++) begin
         for (int src = 0; src < 2; src++) begin
            for (int off = 0; off < 4; off++) begin
               linear = lin[0];
               hi = {2'b01, lin[0], src[0], 2'(off)};
               a0 = {hi, 2'(off)};
               cstart(a0, 1, pat(a0, 8'h5a));
               chk(burst_addr == a0 && wr_lanes == '1 && !rd_valid, "R3",
                   64'(burst_addr), 64'(a0));
               for (int k = 1; k < 4; k++) begin
                  ea = {hi, pos(2'(off), k, lin[0])};
                  adv_n = 0; gwr_n = 0; wdata = pat(ea, 8'h5a);
                  tick();
                  model[ea] = pat(ea, 8'h5a);
                  chk(burst_addr == ea, lin ? "R6" : "R7", 64'(burst_addr), 64'(ea));
                  chk(burst_addr[AW-1:2] == hi, "R9", 64'(burst_addr[AW-1:2]), 64'(hi));
               end
               idle();
               addr = a0;
               if (src == 0) pstb_n = 0; else cstb_n = 0;
               tick();
               idle();
               check_read(a0, src == 0 ? "R2" : "R3");
               for (int k = 1; k < 4; k++) begin
                  ea = {hi, pos(2'(off), k, lin[0])};
                  adv_n = 0;
                  tick();
                  check_read(ea, lin ? "R6" : "R7");
               end
               idle();
            end
         end
      end

      // R8: advance deasserted holds the address
      linear = 1;
      cstart(8'h75, 0, '0);
      check_read(8'h75, "R8");
      repeat (2) begin
         tick();
         check_read(8'h75, "R8");
      end
      adv_n = 0; tick(); idle();
      check_read(8'h76, "R8");

      // R4: ce1_n high blocks the processor strobe, burst continues
      linear = 1;
      cstart(8'h40, 0, '0);
      ce1_n = 1; pstb_n = 0; addr = 8'hc3; adv_n = 0;
      tick(); idle();
      check_read(8'h41, "R4");

      // R5: both strobes, processor wins and write is ignored
      addr = 8'h44; pstb_n = 0; cstb_n = 0; gwr_n = 0; wdata = 32'hffff_ffff;
      tick(); idle();
      check_read(8'h44, "R5");
      cstart(8'h44, 0, '0);
      check_read(8'h44, "R5");
      // R5: with ce1_n high the controller strobe starts an unselected burst
      ce1_n = 1; pstb_n = 0; cstb_n = 0; addr = 8'h48;
      tick(); idle();
      chk(!rd_valid && wr_lanes == '0, "R5", {rd_valid, wr_lanes}, 0);

      // R10 R11: all lane-enable patterns
      for (int m = 0; m < 16; m++) begin
         a0 = 8'h10 + 8'(m);
         lane_we_n = '1;
         cstart(a0, 1, pat(a0, 8'h11));
         chk(wr_lanes == '1 && !rd_valid, "R10", 64'(wr_lanes), 64'hf);
         nd = pat(a0, 8'hc7);
         cstb_n = 0; addr = a0; bwq_n = 0; lane_we_n = ~4'(m); wdata = nd;
         tick(); idle();
         if (m == 0) begin
            chk(rd_valid && wr_lanes == '0, "R11", {rd_valid, wr_lanes}, 64'h10);
         end else begin
            chk(wr_lanes == 4'(m) && !rd_valid, "R11", 64'(wr_lanes), 64'(m));
         end
         model[a0] = (model[a0] & ~lane_mask(4'(m))) | (nd & lane_mask(4'(m)));
         cstart(a0, 0, '0);
         check_read(a0, "R11");
      end
      // R11: qualifier high blocks lane enables
      cstb_n = 0; addr = 8'h12; bwq_n = 1; lane_we_n = '0; wdata = '0;
      tick(); idle();
      check_read(8'h12, "R11");
      // R10: global write ignores lane enables and qualifier
      cstb_n = 0; addr = 8'h13; bwq_n = 1; lane_we_n = '1; gwr_n = 0;
      wdata = 32'h1234_5678;
      tick(); idle();
      model[8'h13] = 32'h1234_5678;
      chk(wr_lanes == '1, "R10", 64'(wr_lanes), 64'hf);
      cstart(8'h13, 0, '0);
      check_read(8'h13, "R10");

      // R12: sleep freezes everything
      linear = 0;
      cstart(8'h40, 0, '0);
      adv_n = 0; tick(); idle();
      check_read(8'h41, "R12");
      ref_a = 8'h41;
      sleep = 1; adv_n = 0; gwr_n = 0; cstb_n = 0; addr = 8'h99;
      wdata = 32'hdead_beef;
      repeat (2) begin
         tick();
         chk(!rd_valid && wr_lanes == '0 && burst_addr == ref_a, "R12",
             {rd_valid, wr_lanes, burst_addr}, 64'(ref_a));
      end
      idle(); adv_n = 0;
      tick(); idle();
      check_read(8'h42, "R12");
      cstart(8'h99, 0, '0);
      chk(rd_valid && rdata != 32'hdead_beef, "R12", 64'(rdata), 0);

      // R13: start with an inactive select, then advance
      ce2 = 0; cstb_n = 0; addr = 8'h40;
      tick(); idle();
      chk(!rd_valid && wr_lanes == '0 && burst_addr == 8'h99, "R13",
          {rd_valid, burst_addr}, 64'h99);
      adv_n = 0; gwr_n = 0; tick(); idle();
      chk(!rd_valid && wr_lanes == '0, "R13", {rd_valid, wr_lanes}, 0);
      ce3_n = 1; cstb_n = 0; addr = 8'h40;
      tick(); idle();
      adv_n = 0; tick(); idle();
      chk(!rd_valid && wr_lanes == '0, "R13", {rd_valid, wr_lanes}, 0);
      cstart(8'h40, 0, '0);
      check_read(8'h40, "R13");

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule